// File: doc/BRIEF.md
# Clock-Enable Driven Rate Decimator

This block lowers the rate of a sample stream by an integer factor inside a single clock domain. Two strobes drive it. The source strobe `srcEn` marks every cycle that carries a valid input sample. The destination strobe `dstEn` marks the end of each output period. Every group of `RATIO` consecutive input samples forms a frame, and the block produces one output value per frame. That value is either the first or the last sample of the frame, and the output holds it until the next value is taken. The input is a bundle of `LANES` independent lanes, each `WIDTH` bits wide, and all lanes share one set of strobes.

Three structures can be chosen at compile time:

- **Zero latency, first sample.** A multiplexer puts the frame's first sample on the output during that same sample. From the frame's second sample onward, the output comes from a register that captured the first sample.
- **Registered, first sample.** The first sample is captured at the start of the frame. A second register copies it to the output at the end of the frame.
- **Registered, last sample.** One register captures the sample that carries `dstEn`, and the output presents it during the following frame.

The first-sample structures use a one-bit register that remembers "the next source sample opens a frame". This realigns the destination strobe from the end of a period to its start. The surrounding logic must raise `dstEn` only together with `srcEn`, on the last sample of each frame. Because that register is cleared by reset, the frame in progress at reset is not treated as opened. A first-sample structure therefore reports zero for the frame that follows it. An illegal configuration stops elaboration with a fatal error. Illegal means either zero latency combined with last-sample selection, or a ratio below 2.

Top module: `rate_decimator`

## Requirements
- R1: A synchronous active-high `rst` clears every lane of `dataOut` to zero by the first clock edge at which it is sampled high. `dataOut` stays zero while reset is held.
- R2: With `LATENCY` >= 1 and `TAKE_LAST` = 1, after a clock edge at which `srcEn` and `dstEn` are both high, every lane of `dataOut` equals that cycle's `dataIn`. This holds through the whole following frame.
- R3: With `LATENCY` >= 1 and `TAKE_LAST` = 0, after the edge that ends frame k (k >= 1 counted from reset, frame 0 being the frame in progress at reset), `dataOut` equals the first sample of frame k.
- R4: With `LATENCY` = 0, during the first source sample of frame k (k >= 1), `dataOut` equals the current `dataIn` in the same cycle, with no register delay.
- R5: With `LATENCY` = 0, on every other cycle of frame k (k >= 1), including cycles where `srcEn` is low, `dataOut` equals the first sample of frame k.
- R6: In the registered structures, `dataOut` changes only at an edge where `srcEn` and `dstEn` are both high. Cycles with `srcEn` low leave the output unchanged.
- R7: Each lane l occupies bits [l*WIDTH +: WIDTH] of `dataIn` and `dataOut`, and lanes never mix.
- R8: In both first-sample structures, the output derived from frame 0 is zero. With zero latency this covers all of frame 1 until frame 1's first sample arrives. With registers it covers all of frame 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcEn | input | 1 | Source strobe, one per input sample |
| dstEn | input | 1 | Destination strobe, high with `srcEn` on the last sample of a frame |
| dataIn | input | LANES*WIDTH | Packed input lanes |
| dataOut | output | LANES*WIDTH | Packed decimated output lanes |

## Verification
Several properties are checked on every cycle:

- Reset clearing.
- The last-sample capture, which relates `dataOut` to the previous `dataIn` at the frame end.
- Output stability between frame ends in the registered structures.
- Output stability across idle source cycles in the zero-latency structure.

Some behaviours can only be shown by the bench's scenarios, which run all three structures side by side against a frame model. These are:

- Which sample of the frame is selected.
- The same-cycle bypass at the frame start.
- The zero output that follows the frame in progress at reset.
- Independence of lanes under random data.

// File: rtl/decim_pkg.sv
package decim_pkg;

  typedef enum logic [1:0] {
    VAR_ZERO_FIRST = 2'd0,
    VAR_REG_FIRST  = 2'd1,
    VAR_REG_LAST   = 2'd2
  } variant_e;

  // Strobes from control to datapath.
  // capEn : load the capture register(s)
  // selEn : zero-latency bypass select, or output-register load
  typedef struct packed {
    logic capEn;
    logic selEn;
  } strobe_t;

  function automatic variant_e pickVariant(input int latency, input bit takeLast);
    if (latency == 0) return VAR_ZERO_FIRST;
    else if (takeLast) return VAR_REG_LAST;
    else return VAR_REG_FIRST;
  endfunction

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl #(
  parameter decim_pkg::variant_e VARIANT = decim_pkg::VAR_REG_LAST
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                srcEn,
  input  logic                dstEn,
  output decim_pkg::strobe_t  stb
);
  import decim_pkg::*;

  logic endStb;
  assign endStb = srcEn & dstEn;

  if (VARIANT == VAR_REG_LAST) begin : g_noAlign
    always_comb begin
      stb.capEn = endStb;
      stb.selEn = endStb;
    end
  end else begin : g_align
    // Remembers that the previous source sample closed a frame, so the
    // next source sample opens one: the destination strobe moved to the start.
    logic frameOpenQ;
    logic startStb;

    always_ff @(posedge clk) begin
      if (rst) frameOpenQ <= 1'b0;
      else if (srcEn) frameOpenQ <= dstEn;
    end

    assign startStb = srcEn & frameOpenQ;

    if (VARIANT == VAR_ZERO_FIRST) begin : g_zl
      always_comb begin
        stb.capEn = startStb;
        stb.selEn = startStb;
      end
    end else begin : g_rf
      always_comb begin
        stb.capEn = startStb;
        stb.selEn = endStb;
      end
    end
  end

endmodule

// File: rtl/decim_datapath.sv
module decim_datapath #(
  parameter int                  LANES   = 4,
  parameter int                  WIDTH   = 8,
  parameter decim_pkg::variant_e VARIANT = decim_pkg::VAR_REG_LAST,
  localparam int                 VEC     = LANES * WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  decim_pkg::strobe_t stb,
  input  logic [VEC-1:0]     dataIn,
  output wire  [VEC-1:0]     dataOut
);
  import decim_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WIDTH-1:0] inLane;
    assign inLane = dataIn[l*WIDTH +: WIDTH];

    if (VARIANT == VAR_ZERO_FIRST) begin : g_zl
      logic [WIDTH-1:0] holdQ;
      always_ff @(posedge clk) begin
        if (rst) holdQ <= '0;
        else if (stb.capEn) holdQ <= inLane;
      end
      assign dataOut[l*WIDTH +: WIDTH] = stb.selEn ? inLane : holdQ;
    end else if (VARIANT == VAR_REG_FIRST) begin : g_rf
      logic [WIDTH-1:0] firstQ;
      logic [WIDTH-1:0] outQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          firstQ <= '0;
          outQ   <= '0;
        end else begin
          if (stb.capEn) firstQ <= inLane;
          if (stb.selEn) outQ   <= firstQ;
        end
      end
      assign dataOut[l*WIDTH +: WIDTH] = outQ;
    end else begin : g_rl
      logic [WIDTH-1:0] outQ;
      always_ff @(posedge clk) begin
        if (rst) outQ <= '0;
        else if (stb.capEn & stb.selEn) outQ <= inLane;
      end
      assign dataOut[l*WIDTH +: WIDTH] = outQ;
    end
  end

endmodule

// File: rtl/rate_decimator.sv
module rate_decimator #(
  parameter int LANES     = 4,
  parameter int WIDTH     = 8,
  parameter int RATIO     = 4,
  parameter int LATENCY   = 1,
  parameter bit TAKE_LAST = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   srcEn,
  input  logic                   dstEn,
  input  logic [LANES*WIDTH-1:0] dataIn,
  output logic [LANES*WIDTH-1:0] dataOut
);
  import decim_pkg::*;

  localparam variant_e VARIANT = pickVariant(LATENCY, TAKE_LAST);

  if (RATIO < 2 || (LATENCY == 0 && TAKE_LAST)) begin : g_badCfg
    $fatal(1, "rate_decimator: illegal RATIO/LATENCY/TAKE_LAST combination");
  end

  strobe_t stb;

  decim_ctrl #(.VARIANT(VARIANT)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .srcEn (srcEn),
    .dstEn (dstEn),
    .stb   (stb)
  );

  decim_datapath #(
    .LANES   (LANES),
    .WIDTH   (WIDTH),
    .VARIANT (VARIANT)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/rate_decimator_chk.sv
module rate_decimator_chk #(
  parameter int LANES     = 4,
  parameter int WIDTH     = 8,
  parameter int LATENCY   = 1,
  parameter bit TAKE_LAST = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   srcEn,
  input logic                   dstEn,
  input logic [LANES*WIDTH-1:0] dataIn,
  input logic [LANES*WIDTH-1:0] dataOut
);

  // R1: reset clears the output
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> dataOut == '0);

  if (LATENCY == 0) begin : g_zl
    // R5: idle source cycles hold the zero-latency output
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!srcEn && !$past(srcEn) && !$past(rst)) |-> $stable(dataOut));
  end else begin : g_reg
    // R6: registered output moves only at a frame end
    a_r6_hold_between_ends: assert property (@(posedge clk) disable iff (rst)
      (!(srcEn && dstEn)) |=> $stable(dataOut));
    if (TAKE_LAST) begin : g_last
      // R2: last sample of the frame is presented next
      a_r2_last_capture: assert property (@(posedge clk) disable iff (rst)
        (srcEn && dstEn) |=> dataOut == $past(dataIn));
    end
  end

endmodule

bind rate_decimator rate_decimator_chk #(
  .LANES(LANES), .WIDTH(WIDTH), .LATENCY(LATENCY), .TAKE_LAST(TAKE_LAST)
) chk_i (.*);

// File: tb/rate_decimator_tb_top.sv
module rate_decimator_tb_top;
  localparam int LANES = 4;
  localparam int WIDTH = 8;
  localparam int R     = 4;
  localparam int VEC   = LANES * WIDTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic srcEn = 1'b0;
  logic dstEn = 1'b0;
  logic [VEC-1:0] dataIn = '0;
  logic [VEC-1:0] outZl, outRf, outRl;

  always #5 clk = ~clk;

  rate_decimator #(.LANES(LANES), .WIDTH(WIDTH), .RATIO(R), .LATENCY(0), .TAKE_LAST(1'b0))
    dut_i (.clk(clk), .rst(rst), .srcEn(srcEn), .dstEn(dstEn), .dataIn(dataIn), .dataOut(outZl));
  rate_decimator #(.LANES(LANES), .WIDTH(WIDTH), .RATIO(R), .LATENCY(1), .TAKE_LAST(1'b0))
    dut_f (.clk(clk), .rst(rst), .srcEn(srcEn), .dstEn(dstEn), .dataIn(dataIn), .dataOut(outRf));
  rate_decimator #(.LANES(LANES), .WIDTH(WIDTH), .RATIO(R), .LATENCY(1), .TAKE_LAST(1'b1))
    dut_l (.clk(clk), .rst(rst), .srcEn(srcEn), .dstEn(dstEn), .dataIn(dataIn), .dataOut(outRl));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // frame model
  int pos = 0;
  int frame = 0;
  logic [VEC-1:0] curFirst = '0;
  logic [VEC-1:0] firstDone = '0;
  logic [VEC-1:0] lastCap = '0;

  function automatic logic [VEC-1:0] expZl(input bit s, input logic [VEC-1:0] d);
    return (s && pos == 0 && frame > 0) ? d : curFirst;
  endfunction

  // per-lane compare; R7 is part of every comparison
  task automatic cmp(input string tag, input string name,
                     input logic [VEC-1:0] act, input logic [VEC-1:0] exp);
    for (int l = 0; l < LANES; l++) begin
      checks++;
      if (act[l*WIDTH +: WIDTH] !== exp[l*WIDTH +: WIDTH]) begin
        fails++;
        $display("FAIL %s (R7 lane %0d) %s: actual %h expected %h",
                 tag, l, name, act[l*WIDTH +: WIDTH], exp[l*WIDTH +: WIDTH]);
      end
    end
  endtask

  task automatic stepCycle(input bit s, input logic [VEC-1:0] d);
    @(negedge clk);
    srcEn  = s;
    dstEn  = s && (pos == R - 1);
    dataIn = d;
    #2;
    if (s && pos == 0 && frame > 0) cmp("R4", "zero-latency bypass", outZl, expZl(s, d));
    else if (frame <= 1)            cmp("R8", "zero-latency startup", outZl, expZl(s, d));
    else                            cmp("R5", "zero-latency hold", outZl, expZl(s, d));
    if (frame <= 1)  cmp("R8", "registered-first startup", outRf, firstDone);
    else if (!s)     cmp("R6", "registered-first idle", outRf, firstDone);
    else             cmp("R3", "registered-first", outRf, firstDone);
    if (!s) cmp("R6", "registered-last idle", outRl, lastCap);
    else    cmp("R2", "registered-last", outRl, lastCap);
    if (s) begin
      if (pos == 0 && frame > 0) curFirst = d;
      if (pos == R - 1) begin
        firstDone = curFirst;
        lastCap   = d;
        frame++;
      end
      pos = (pos + 1) % R;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    srcEn = 1'b0;
    dstEn = 1'b0;
    dataIn = $urandom;
    @(negedge clk);
    @(negedge clk);
    #2;
    cmp("R1", "reset zl", outZl, '0);
    cmp("R1", "reset rf", outRf, '0);
    cmp("R1", "reset rl", outRl, '0);
    rst = 1'b0;
    pos = 0; frame = 0; curFirst = '0; firstDone = '0; lastCap = '0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    doReset();
    for (int i = 0; i < 400; i++) stepCycle(($urandom % 4) != 0, $urandom);
    for (int i = 0; i < 20; i++) stepCycle(1'b0, $urandom);          // long idle gap
    for (int i = 0; i < 200; i++) stepCycle(($urandom % 3) == 0, $urandom);
    for (int i = 0; i < 7; i++) stepCycle(1'b1, $urandom);           // mid-frame reset follows
    doReset();
    for (int i = 0; i < 12; i++) stepCycle(1'b1, {LANES{8'hFF}} ^ VEC'(i)); // near-all-ones lanes
    for (int i = 0; i < 100; i++) stepCycle(1'b1, $urandom);          // dense source strobe
    for (int i = 0; i < 300; i++) stepCycle(($urandom % 4) != 0, $urandom);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule